// File: doc/BRIEF.md
# Throttled Burst Data-Phase Engine

This block runs one granted data phase on a shared 32-bit-per-transfer data bus, either a read response sent by the host or write data sent by the card. Both roles are modelled in one module. The host's readiness and the card's readiness arrive on separate active-low inputs. The engine drives the active-low data-valid strobe of the sending side, the per-lane byte enables, and the index of the first transfer carried in the current clock. The parameter `XPC` sets how many 32-bit transfers fit in one clock. The byte-enable bus therefore has one 4-bit lane for each of those transfers.

The burst moves in blocks of four clocks. The first block is sent with no acknowledgement. On the third clock of every block that has more data behind it, the engine samples readiness. Reads need both sides ready. Writes need only the host, because the card cannot hold back write data it has already queued. If readiness is missing, the engine holds the bus idle, and data resumes two cycles after the first cycle in which readiness is seen. A burst that ends part-way through a clock fills the unused lanes with dummy transfers whose byte enables are all deasserted. A zero-length request is refused with an error pulse and the bus stays idle.

Top module: `burst_phase_engine`

## Requirements
- R1: The first data clock is the cycle after `start` is sampled while idle. In a data clock of a read, `trdyN` is low and `irdyN` is high. In a data clock of a write, `irdyN` is low and `trdyN` is high.
- R2: The first four data clocks (or all of them, if the burst is shorter) run back to back whatever the ready inputs do.
- R3: In each block, if the continuation condition holds on the third data clock and more data follows the block, the next block's first data clock comes straight after the block's fourth clock.
- R4: If the condition does not hold on that third clock, no data clocks follow the block until the condition is seen in some cycle T. Data then resumes in cycle T+2. In the idle cycles both ready outputs are high.
- R5: For a read the continuation condition is `hostRdyN` low and `cardRdyN` low. For a write it is `hostRdyN` low alone, and `cardRdyN` has no effect.
- R6: Lane j is `cbeN[4j+3:4j]` and carries transfer number `k*XPC+j` in data clock k. A lane that carries a real transfer is 4'h0 in a read and `~wrMask` in a write.
- R7: A lane whose transfer number is at or beyond `xferLen` is a padding lane and is 4'hF. Outside data clocks every lane is 4'hF.
- R8: `done` is high exactly in the last data clock. In the cycle after it, both ready outputs are high.
- R9: A `start` with `xferLen` of zero while idle gives a one-cycle `err` pulse in the next cycle, and no data clocks follow.
- R10: A `start` while a phase is in progress is ignored. It raises no `err` and does not disturb the running burst.
- R11: In data clock k, `xferIdx` equals `k*XPC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Grant for one data phase, sampled while idle |
| isWrite | input | 1 | 1 for write data, 0 for read response |
| xferLen | input | LEN_W | Burst length in 32-bit transfers |
| wrMask | input | 4 | Active-high byte-write mask applied to each write transfer |
| hostRdyN | input | 1 | Host ready, active low |
| cardRdyN | input | 1 | Card ready, active low |
| irdyN | output | 1 | Card data valid, active low |
| trdyN | output | 1 | Host data valid, active low |
| cbeN | output | 4*XPC | Byte enables, active low, one lane per transfer |
| xferIdx | output | LEN_W | Index of the first transfer in the current clock |
| done | output | 1 | High in the last data clock |
| err | output | 1 | Zero-length request refused |

## Verification
The hardest case to reach is a stall followed by its resume. Readiness has to be missing exactly on a block's third clock and then appear in one chosen idle cycle, so that the T+2 spacing of R4 can be seen. The bench drives the ready inputs at falling edges. It keeps readiness withheld through the third clock, releases it in a known cycle, and checks the idle cycles, the resume cycle and the transfer index that follows. It then holds only one side ready, showing that the same condition stalls a read but not a write.

// File: rtl/bpe_pkg.sv
package bpe_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_WAIT = 2'd2,
    PH_ARM  = 2'd3
  } phase_t;

  typedef struct packed {
    logic load;
    logic step;
    logic active;
  } dpStrb_t;

endpackage

// File: rtl/bpe_ctrl.sv
module bpe_ctrl
  import bpe_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    isWrite,
  input  logic    lenZero,
  input  logic    hostRdyN,
  input  logic    cardRdyN,
  input  logic    lastClk,
  input  logic    beyondBlk,
  output dpStrb_t strb,
  output logic    busy,
  output logic    irdyN,
  output logic    trdyN,
  output logic    done,
  output logic    err
);

  phase_t     state;
  logic [1:0] pos;
  logic       contOk;
  logic       wrReg;
  logic       rdyOk;
  logic       active;

  assign active = (state == PH_DATA);
  assign rdyOk  = wrReg ? !hostRdyN : (!hostRdyN && !cardRdyN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= PH_IDLE;
      pos    <= 2'd0;
      contOk <= 1'b0;
      wrReg  <= 1'b0;
      err    <= 1'b0;
    end else begin
      err <= 1'b0;
      case (state)
        PH_IDLE: begin
          if (start) begin
            if (lenZero) begin
              err <= 1'b1;
            end else begin
              state  <= PH_DATA;
              pos    <= 2'd0;
              contOk <= 1'b0;
              wrReg  <= isWrite;
            end
          end
        end
        PH_DATA: begin
          pos <= pos + 2'd1;
          if (pos == 2'd2) contOk <= beyondBlk && rdyOk;
          if (lastClk) begin
            state <= PH_IDLE;
            pos   <= 2'd0;
          end else if (pos == 2'd3) begin
            contOk <= 1'b0;
            if (!contOk) state <= rdyOk ? PH_ARM : PH_WAIT;
          end
        end
        PH_WAIT: if (rdyOk) state <= PH_ARM;
        PH_ARM:  state <= PH_DATA;
        default: state <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load   = (state == PH_IDLE) && start && !lenZero;
    strb.step   = active;
    strb.active = active;
  end

  assign busy  = (state != PH_IDLE);
  assign done  = active && lastClk;
  assign trdyN = !(active && !wrReg);
  assign irdyN = !(active && wrReg);

endmodule

// File: rtl/bpe_datapath.sv
module bpe_datapath
  import bpe_pkg::*;
#(
  parameter int XPC   = 2,
  parameter int LEN_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrb_t              strb,
  input  logic                 isWrite,
  input  logic [LEN_W-1:0]     xferLen,
  input  logic [3:0]           wrMask,
  output logic                 lastClk,
  output logic                 beyondBlk,
  output logic [4*XPC-1:0]     cbeN,
  output logic [LEN_W-1:0]     xferIdx
);

  localparam logic [LEN_W-1:0] STEP  = LEN_W'(XPC);
  localparam logic [LEN_W-1:0] HALFB = LEN_W'(2 * XPC);

  logic [LEN_W-1:0] remain;
  logic [LEN_W-1:0] idx;
  logic             wr;
  logic [3:0]       mask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
      idx    <= '0;
      wr     <= 1'b0;
      mask   <= 4'h0;
    end else if (strb.load) begin
      remain <= xferLen;
      idx    <= '0;
      wr     <= isWrite;
      mask   <= wrMask;
    end else if (strb.step) begin
      remain <= lastClk ? '0 : remain - STEP;
      idx    <= idx + STEP;
    end
  end

  assign lastClk   = (remain <= STEP);
  assign beyondBlk = (remain > HALFB);
  assign xferIdx   = idx;

  for (genvar j = 0; j < XPC; j++) begin : g_lane
    logic laneLive;
    assign laneLive = strb.active && (remain > LEN_W'(j));
    assign cbeN[4*j +: 4] = !laneLive ? 4'hF : (wr ? ~mask : 4'h0);
  end

endmodule

// File: rtl/burst_phase_engine.sv
module burst_phase_engine
  import bpe_pkg::*;
#(
  parameter int XPC   = 2,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isWrite,
  input  logic [LEN_W-1:0] xferLen,
  input  logic [3:0]       wrMask,
  input  logic             hostRdyN,
  input  logic             cardRdyN,
  output logic             irdyN,
  output logic             trdyN,
  output logic [4*XPC-1:0] cbeN,
  output logic [LEN_W-1:0] xferIdx,
  output logic             done,
  output logic             err
);

  dpStrb_t strb;
  logic    lastClk;
  logic    beyondBlk;
  logic    busy;
  logic    lenZero;

  assign lenZero = (xferLen == '0);

  bpe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite),
    .lenZero(lenZero), .hostRdyN(hostRdyN), .cardRdyN(cardRdyN),
    .lastClk(lastClk), .beyondBlk(beyondBlk), .strb(strb), .busy(busy),
    .irdyN(irdyN), .trdyN(trdyN), .done(done), .err(err)
  );

  bpe_datapath #(.XPC(XPC), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .isWrite(isWrite),
    .xferLen(xferLen), .wrMask(wrMask), .lastClk(lastClk),
    .beyondBlk(beyondBlk), .cbeN(cbeN), .xferIdx(xferIdx)
  );

endmodule

// File: rtl/bpe_checker.sv
module bpe_checker #(
  parameter int XPC   = 2,
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             isWrite,
  input logic [LEN_W-1:0] xferLen,
  input logic             busy,
  input logic             irdyN,
  input logic             trdyN,
  input logic [4*XPC-1:0] cbeN,
  input logic             done,
  input logic             err
);

  // R1: read grant gives host data valid next cycle
  assert_read_first_R1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && xferLen != '0 && !isWrite) |=> (!trdyN && irdyN));

  // R1: write grant gives card data valid next cycle
  assert_write_first_R1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && xferLen != '0 && isWrite) |=> (!irdyN && trdyN));

  // R1: never both sides driving
  assert_one_side_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(!irdyN && !trdyN));

  // R6: read data clock has lane 0 fully enabled
  assert_read_lane0_R6: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |-> (cbeN[3:0] == 4'h0));

  // R7: no data clock means no enabled byte
  assert_idle_cbe_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irdyN && trdyN) |-> (cbeN == '1));

  // R8: bus released after the last clock
  assert_done_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (irdyN && trdyN));

  // R9: zero-length refusal leaves the bus idle
  assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (irdyN && trdyN && !done));

  // R10: grant while busy raises no error
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> !err);

endmodule

bind burst_phase_engine bpe_checker #(.XPC(XPC), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite),
  .xferLen(xferLen), .busy(busy), .irdyN(irdyN), .trdyN(trdyN),
  .cbeN(cbeN), .done(done), .err(err)
);

// File: tb/test_burst_phase_engine.sv
module test_burst_phase_engine;

  localparam int XPC   = 2;
  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic             isWrite = 1'b0;
  logic [LEN_W-1:0] xferLen = '0;
  logic [3:0]       wrMask = 4'h0;
  logic             hostRdyN = 1'b1;
  logic             cardRdyN = 1'b1;
  logic             irdyN, trdyN, done, err;
  logic [4*XPC-1:0] cbeN;
  logic [LEN_W-1:0] xferIdx;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  burst_phase_engine #(.XPC(XPC), .LEN_W(LEN_W)) i_burst_phase_engine (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite),
    .xferLen(xferLen), .wrMask(wrMask), .hostRdyN(hostRdyN),
    .cardRdyN(cardRdyN), .irdyN(irdyN), .trdyN(trdyN), .cbeN(cbeN),
    .xferIdx(xferIdx), .done(done), .err(err)
  );

  // vector: len[15:8], write[4], mask[3:0]
  localparam logic [15:0] VEC [6] = '{
    {8'd2,  4'b0000, 4'h0},
    {8'd5,  4'b0001, 4'hA},
    {8'd8,  4'b0000, 4'h0},
    {8'd11, 4'b0001, 4'h6},
    {8'd1,  4'b0000, 4'h0},
    {8'd9,  4'b0001, 4'hF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4*XPC-1:0] expCbe(input int k, input int len,
                                             input bit wr, input logic [3:0] m);
    logic [4*XPC-1:0] v;
    for (int j = 0; j < XPC; j++)
      v[4*j +: 4] = (k*XPC + j < len) ? (wr ? ~m : 4'h0) : 4'hF;
    return v;
  endfunction

  task automatic chkData(input int k, input int len, input bit wr,
                         input logic [3:0] m, input string tag);
    chk({tag, " R1 trdyN"}, 32'(trdyN), 32'(wr));
    chk({tag, " R1 irdyN"}, 32'(irdyN), 32'(!wr));
    chk({tag, " R6 R7 cbeN"}, 32'(cbeN), 32'(expCbe(k, len, wr, m)));
    chk({tag, " R11 xferIdx"}, 32'(xferIdx), 32'(k*XPC));
    chk({tag, " R8 done"}, 32'(done), 32'((k+1)*XPC >= len));
  endtask

  task automatic chkIdle(input string tag);
    chk({tag, " R4 R8 trdyN idle"}, 32'(trdyN), 32'd1);
    chk({tag, " R4 R8 irdyN idle"}, 32'(irdyN), 32'd1);
    chk({tag, " R7 cbeN idle"}, 32'(cbeN), 32'(8'hFF));
  endtask

  task automatic grant(input int len, input bit wr, input logic [3:0] m);
    xferLen = LEN_W'(len);
    isWrite = wr;
    wrMask  = m;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chkIdle("reset");
    chk("reset R8 done", 32'(done), 32'd0);
    chk("reset R9 err", 32'(err), 32'd0);

    // table walk, both sides always ready: R2 R3 back-to-back clocks
    hostRdyN = 1'b0;
    cardRdyN = 1'b0;
    for (int v = 0; v < 6; v++) begin
      int len = int'(VEC[v][15:8]);
      bit wr = VEC[v][4];
      int nClk = (len + XPC - 1) / XPC;
      grant(len, wr, VEC[v][3:0]);
      for (int k = 0; k < nClk; k++) begin
        chkData(k, len, wr, VEC[v][3:0], "table R3");
        @(negedge clk);
      end
      chkIdle("table end");
    end

    // R4: stall on read, release in cycle 5, resume in cycle 7
    hostRdyN = 1'b1;
    grant(20, 1'b0, 4'h0);
    for (int k = 0; k < 4; k++) begin
      chkData(k, 20, 1'b0, 4'h0, "stall R2 block0");
      @(negedge clk);
    end
    chkIdle("stall wait4");
    @(negedge clk);
    chkIdle("stall wait5");
    hostRdyN = 1'b0;
    @(negedge clk);
    chkIdle("stall arm6");
    @(negedge clk);
    for (int k = 4; k < 10; k++) begin
      chkData(k, 20, 1'b0, 4'h0, "stall R4 resume");
      @(negedge clk);
    end
    chkIdle("stall end");

    // R5: read stalls when only card is not ready
    cardRdyN = 1'b1;
    grant(12, 1'b0, 4'h0);
    for (int k = 0; k < 4; k++) begin
      chkData(k, 12, 1'b0, 4'h0, "card R5 block0");
      @(negedge clk);
    end
    chkIdle("card R5 wait");
    cardRdyN = 1'b0;
    @(negedge clk);
    chkIdle("card R5 arm");
    @(negedge clk);
    for (int k = 4; k < 6; k++) begin
      chkData(k, 12, 1'b0, 4'h0, "card R5 resume");
      @(negedge clk);
    end

    // R5: write ignores card readiness
    cardRdyN = 1'b1;
    grant(12, 1'b1, 4'h3);
    for (int k = 0; k < 6; k++) begin
      chkData(k, 12, 1'b1, 4'h3, "write R5 no stall");
      @(negedge clk);
    end
    chkIdle("write R5 end");
    cardRdyN = 1'b0;

    // R9: zero length refused
    grant(0, 1'b0, 4'h0);
    chk("zero R9 err", 32'(err), 32'd1);
    chkIdle("zero R9 bus");
    @(negedge clk);
    chk("zero R9 err pulse", 32'(err), 32'd0);
    chkIdle("zero R9 after");

    // R10: grant during a phase is ignored
    grant(8, 1'b0, 4'h0);
    chkData(0, 8, 1'b0, 4'h0, "busy R10 clk0");
    xferLen = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("busy R10 err", 32'(err), 32'd0);
    for (int k = 1; k < 4; k++) begin
      chkData(k, 8, 1'b0, 4'h0, "busy R10 run");
      @(negedge clk);
    end
    chkIdle("busy R10 end");

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule